// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a four-wire serial configuration bus. An external controller lowers an active-low select, sets a direction line, and clocks sixteen bits onto a data line. The first eight bits are an address and the last eight are data, both sent most-significant bit first. A write places the data byte into one of the block's configuration registers. A read returns the addressed byte on the same data line, which the block drives only while data bits are being returned. The serial clock is treated as asynchronous. It is oversampled by the master clock, which must run at least twice as fast, after every serial input has passed through a synchronizer.

The register space has 32 decoded indices. The index is the address with its two low bits dropped, so index n sits at byte address 4n. Indices 16 and 17 each have a second copy, and bit 7 of register 5 decides which copy is reached. That gives 34 stored bytes in total. Five indices return live status bytes supplied by the surrounding design, and writes to them do nothing. Every stored byte is presented on a flat output bus for the rest of the chip.

Top module: `cfg_serial_port`

## Requirements
- R1: A transfer is 8 address bits followed by 8 data bits, MSB first, each sampled on a rising edge of `sck`. A write (`rd_wr` low) stores the data byte in the register whose index is address bits 7:2. The register appears on `cfg_out[8k+7:8k]`, where k is the storage slot.
- R2: Address bits 1:0 are ignored. Any value there reaches the same register.
- R3: During a read, `sd_oe` rises after the 8th rising edge. It stays high through the 8 data bits, which `sd_o` presents MSB first, each stable before the next rising edge. `sd_oe` falls after the 16th rising edge. It is low throughout the address phase.
- R4: `rd_wr` high selects a read, and it is taken at the 8th rising edge. A read changes no register.
- R5: `ss_n` high clears the transfer state and releases `sd_oe`. A transfer that ends before its 16th rising edge changes nothing. If `ss_n` rises in the same master-clock cycle as the 16th rising edge, the transfer is also dropped. The next transfer starts from bit zero.
- R6: While register 5 bit 7 is 0, indices 16 and 17 reach slots 16 and 17. While it is 1, they reach slots 32 and 33. Reads and writes follow the same routing.
- R7: Indices 24, 25, 26, 27 and 29 are read-only. A read of them returns `stat_in` byte 0, 1, 2, 3 and 4 respectively (byte j at bits 8j+7:8j). A write to them leaves every slot of `cfg_out` unchanged, and those slots read zero on `cfg_out`.
- R8: After reset, every slot of `cfg_out` is zero and `sd_oe` is low.
- R9: Indices 32 to 63 are unmapped. Writes to them change nothing, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Active-low transfer select from the bus master |
| sck | input | 1 | Serial bit clock, asynchronous, at most half of `clk` |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| sd_i | input | 1 | Serial data from the bus master |
| sd_o | output | 1 | Serial read data toward the bus master |
| sd_oe | output | 1 | Drive enable for the shared data pin |
| stat_in | input | 40 | Five read-only status bytes |
| cfg_out | output | 272 | All 34 stored register bytes, slot k at bits 8k+7:8k |

## Verification
Two events can share a master-clock cycle. One is the detection of the final rising edge, which commits a write. The other is the select line going inactive, which clears the transfer. The bench provokes this by raising `sck` and `ss_n` at the same instant on the last bit. It then judges the result on `cfg_out`: the targeted register must keep its old value, and a following ordinary write must land normally. A second overlap is a write to register 5 that flips the copy select. The bench interleaves such writes with accesses to indices 16 and 17 and checks each access against the routing in force when it was decoded.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   // register map constants
   localparam int NUM_ADDR  = 32;
   localparam int NUM_ALT   = 2;
   localparam int NUM_REG   = NUM_ADDR + NUM_ALT;
   localparam int ALT_BASE  = 16;
   localparam int SEL_REG   = 5;
   localparam int SEL_BIT   = 7;
   localparam int NUM_STAT  = 5;
   localparam int STAT_IDX4 = 29;
   localparam int STAT_BASE = 24;
   localparam logic [NUM_ADDR-1:0] RO_MASK = 32'h2F00_0000;

   function automatic bit idx_mapped(int idx);
      return (idx >= 0) && (idx < NUM_ADDR);
   endfunction

   function automatic bit idx_ro(int idx);
      if (!idx_mapped(idx)) return 1'b0;
      return RO_MASK[idx[4:0]];
   endfunction

   function automatic int phys_of(int idx, bit sel);
      if (sel && (idx >= ALT_BASE) && (idx < ALT_BASE + NUM_ALT))
         return NUM_ADDR + (idx - ALT_BASE);
      return idx;
   endfunction

   function automatic int stat_slot(int idx);
      return (idx == STAT_IDX4) ? 4 : (idx - STAT_BASE);
   endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d_async[b]};
         end
         assign q_sync[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cfg_serial_fsm.sv
module cfg_serial_fsm #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int ADDR_IGN = 2,
   localparam int IDX_W   = ADDR_W - ADDR_IGN,
   localparam int SH_W    = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
   localparam int NBITS   = ADDR_W + DATA_W,
   localparam int CNT_W   = $clog2(NBITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sck_s,
   input  logic              sd_s,
   input  logic              rd_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              sd_o,
   output logic              sd_oe
);
   localparam logic [CNT_W-1:0] C_ADDR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] C_DATA_LAST = CNT_W'(NBITS - 1);
   localparam logic [CNT_W-1:0] C_DONE      = CNT_W'(NBITS);

   logic              sck_q;
   logic              sck_rise;
   logic [CNT_W-1:0]  cnt;
   logic [SH_W-2:0]   sh_in;
   logic [IDX_W-1:0]  idx_q;
   logic              rd_q;
   logic [DATA_W-1:0] tx;

   assign sck_rise = sck_s & ~sck_q;
   assign rd_idx   = sh_in[ADDR_W-2:ADDR_IGN-1];
   assign wr_data  = {sh_in[DATA_W-2:0], sd_s};
   assign wr_idx   = idx_q;
   assign wr_en    = cs_act & sck_rise & (cnt == C_DATA_LAST) & ~rd_q;
   assign sd_o     = tx[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cnt   <= '0;
         sh_in <= '0;
         idx_q <= '0;
         rd_q  <= 1'b0;
         tx    <= '0;
         sd_oe <= 1'b0;
      end else begin
         sck_q <= sck_s;
         if (!cs_act) begin
            cnt   <= '0;
            rd_q  <= 1'b0;
            sd_oe <= 1'b0;
         end else if (sck_rise && cnt != C_DONE) begin
            cnt   <= cnt + 1'b1;
            sh_in <= {sh_in[SH_W-3:0], sd_s};
            if (cnt == C_ADDR_LAST) begin
               idx_q <= rd_idx;
               rd_q  <= rd_s;
               if (rd_s) begin
                  tx    <= rd_data;
                  sd_oe <= 1'b1;
               end
            end else if (cnt == C_DATA_LAST) begin
               sd_oe <= 1'b0;
            end else if (cnt > C_ADDR_LAST) begin
               tx <= {tx[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (cnt == '0) && !sd_oe);
   a_r3_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
      sd_oe |-> (cnt > C_ADDR_LAST) && (cnt <= C_DATA_LAST));
   a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_oe && !sck_rise) |=> ($stable(sd_o) || !sd_oe));
   a_r4_read_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      sd_oe |-> !wr_en);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfg_port_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 6,
   localparam int PH_W  = $clog2(NUM_REG),
   localparam int ST_W  = $clog2(NUM_STAT)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [NUM_STAT*DATA_W-1:0] stat_in,
   output logic [NUM_REG*DATA_W-1:0]  cfg_out
);
   logic [NUM_REG-1:0][DATA_W-1:0]  regs;
   logic [NUM_STAT-1:0][DATA_W-1:0] stat_v;
   logic                            sel;
   logic [PH_W-1:0]                 wr_ph, rd_ph;
   logic [ST_W-1:0]                 rd_slot;
   logic                            wr_ok;

   assign stat_v  = stat_in;
   assign sel     = regs[SEL_REG][SEL_BIT];
   assign wr_ph   = PH_W'(phys_of(int'(wr_idx), sel));
   assign rd_ph   = PH_W'(phys_of(int'(rd_idx), sel));
   assign rd_slot = ST_W'(stat_slot(int'(rd_idx)));
   assign wr_ok   = wr_en && idx_mapped(int'(wr_idx)) && !idx_ro(int'(wr_idx));
   assign cfg_out = regs;

   always_comb begin
      if (!idx_mapped(int'(rd_idx)))  rd_data = '0;
      else if (idx_ro(int'(rd_idx)))  rd_data = stat_v[rd_slot];
      else                            rd_data = regs[rd_ph];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs <= '0;
      else if (wr_ok) regs[wr_ph] <= wr_data;
   end

   a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> regs[$past(wr_ph)] == $past(wr_data));
   a_r7_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx_ro(int'(wr_idx))) |=> regs == $past(regs));
   a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !idx_mapped(int'(wr_idx))) |=> regs == $past(regs));
   a_r6_alt_routing: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel && int'(wr_idx) == ALT_BASE) |=>
         regs[ALT_BASE] == $past(regs[ALT_BASE]));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfg_port_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int ADDR_IGN    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = ADDR_W - ADDR_IGN
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ss_n,
   input  logic                       sck,
   input  logic                       rd_wr,
   input  logic                       sd_i,
   output logic                       sd_o,
   output logic                       sd_oe,
   input  logic [NUM_STAT*DATA_W-1:0] stat_in,
   output logic [NUM_REG*DATA_W-1:0]  cfg_out
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_IGN < 1) begin : g_bad_ign
         $error("ADDR_IGN must be at least 1");
      end
      if ((1 << IDX_W) < NUM_ADDR) begin : g_bad_idx
         $error("address too narrow for the register map");
      end
      if (DATA_W <= SEL_BIT) begin : g_bad_dw
         $error("DATA_W too narrow for the copy select bit");
      end
   endgenerate

   logic [3:0]        sync_q;
   logic              ss_s, sck_s, sd_s, rd_s;
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en;

   cfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ss_n, sck, sd_i, rd_wr}),
      .q_sync  (sync_q)
   );
   assign {ss_s, sck_s, sd_s, rd_s} = sync_q;

   cfg_serial_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_IGN(ADDR_IGN)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_act  (~ss_s),
      .sck_s   (sck_s),
      .sd_s    (sd_s),
      .rd_s    (rd_s),
      .rd_data (rd_data),
      .rd_idx  (rd_idx),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .sd_o    (sd_o),
      .sd_oe   (sd_oe)
   );

   cfg_reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .stat_in (stat_in),
      .cfg_out (cfg_out)
   );

   a_r5_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      ss_s |=> !sd_oe);
endmodule

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb_top;
   localparam int CLK_P = 10;
   localparam int HALF  = 4;
   localparam int NREG  = 34;

   logic         clk = 0;
   logic         rst_n = 0;
   logic         ss_n = 1, sck = 0, rd_wr = 0, sd_i = 0;
   logic         sd_o, sd_oe;
   logic [39:0]  stat_in = '0;
   logic [271:0] cfg_out;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] mdl [NREG];

   always #(CLK_P/2) clk = ~clk;

   cfg_serial_port dut_i (
      .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .rd_wr(rd_wr),
      .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe), .stat_in(stat_in), .cfg_out(cfg_out)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit is_ro(int idx);
      return idx == 24 || idx == 25 || idx == 26 || idx == 27 || idx == 29;
   endfunction

   function automatic int slot_of(int idx);
      if (mdl[5][7] && (idx == 16 || idx == 17)) return idx + 16;
      return idx;
   endfunction

   function automatic logic [7:0] exp_read(int idx);
      if (idx >= 32) return 8'h00;
      if (is_ro(idx)) return stat_in[((idx == 29) ? 4 : idx - 24)*8 +: 8];
      return mdl[slot_of(idx)];
   endfunction

   task automatic model_write(int idx, logic [7:0] d);
      if (idx < 32 && !is_ro(idx)) mdl[slot_of(idx)] = d;
   endtask

   task automatic check_bank(input string req);
      int bad = -1;
      for (int k = 0; k < NREG; k++)
         if (cfg_out[k*8 +: 8] !== mdl[k] && bad < 0) bad = k;
      if (bad < 0) chk(1, req, 0, 0);
      else chk(0, {req, " cfg_out slot"}, {24'h0, cfg_out[bad*8 +: 8]}, {24'h0, mdl[bad]});
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   // nbits < 16 aborts; late_abort raises ss_n together with the last sck rise
   task automatic xfer(input bit rd, input logic [7:0] addr, input logic [7:0] wd,
                       input int nbits, input bit late_abort, output logic [7:0] rdat);
      rdat = 'x;
      ss_n = 0; rd_wr = rd; sck = 0;
      tick(HALF);
      for (int i = 0; i < nbits; i++) begin
         sd_i = (i < 8) ? addr[7-i] : wd[15-i];
         sck = 0;
         tick(HALF);
         if (rd && i >= 8) begin
            chk(sd_oe === 1'b1, "R3 oe during data", {31'h0, sd_oe}, 1);
            rdat[15-i] = sd_o;
         end else if (rd && i == 7) begin
            chk(sd_oe === 1'b0, "R3 oe low in address phase", {31'h0, sd_oe}, 0);
         end
         sck = 1;
         if (late_abort && i == nbits - 1) ss_n = 1;
         tick(HALF);
      end
      sck = 0;
      tick(HALF);
      if (rd && nbits == 16 && !late_abort)
         chk(sd_oe === 1'b0, "R3 oe released after last bit", {31'h0, sd_oe}, 0);
      ss_n = 1;
      tick(6);
      chk(sd_oe === 1'b0, "R5 oe low when deselected", {31'h0, sd_oe}, 0);
   endtask

   task automatic do_wr(int idx, logic [7:0] d, logic [1:0] lo);
      logic [7:0] r;
      xfer(0, {idx[5:0], lo}, d, 16, 0, r);
      model_write(idx, d);
   endtask

   task automatic do_rd(int idx, logic [1:0] lo, input string req);
      logic [7:0] r, e;
      e = exp_read(idx);
      xfer(1, {idx[5:0], lo}, 8'h00, 16, 0, r);
      chk(r === e, req, {24'h0, r}, {24'h0, e});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
      tick(3);
      rst_n = 1;
      tick(4);
      // R8 reset state
      chk(cfg_out === '0, "R8 registers zero after reset", 0, 0);
      chk(sd_oe === 1'b0, "R8 oe low after reset", {31'h0, sd_oe}, 0);

      // R1 / R2 basic write with ignored low bits, then read back
      do_wr(3, 8'hA5, 2'b11);
      check_bank("R1 R2 write index 3");
      do_rd(3, 2'b00, "R1 R4 read back index 3");
      check_bank("R4 read leaves registers");
      do_wr(31, 8'h3C, 2'b01);
      do_rd(31, 2'b10, "R2 low address bits ignored");

      // R6 shadow routing
      do_wr(16, 8'h11, 2'b00);
      do_wr(17, 8'h12, 2'b00);
      do_wr(5, 8'h80, 2'b00);
      do_wr(16, 8'h22, 2'b00);
      do_wr(17, 8'h23, 2'b00);
      check_bank("R6 alternate copies written");
      do_rd(16, 2'b00, "R6 read alternate 16");
      do_wr(5, 8'h00, 2'b00);
      do_rd(17, 2'b00, "R6 read primary 17");

      // R7 read-only status
      stat_in = 40'h55_44_33_22_11;
      do_wr(24, 8'hFF, 2'b00);
      do_wr(29, 8'hEE, 2'b00);
      check_bank("R7 write to status ignored");
      do_rd(24, 2'b00, "R7 status byte 0");
      do_rd(29, 2'b00, "R7 status byte 4");

      // R9 unmapped
      do_wr(40, 8'h99, 2'b00);
      check_bank("R9 unmapped write ignored");
      do_rd(63, 2'b00, "R9 unmapped read zero");

      // R5 aborts, including deselect in the same cycle as the last edge
      xfer(0, {6'd3, 2'b00}, 8'h00, 12, 0, r);
      check_bank("R5 short transfer dropped");
      xfer(0, {6'd3, 2'b00}, 8'h00, 16, 1, r);
      check_bank("R5 deselect with final edge dropped");
      xfer(1, {6'd3, 2'b00}, 8'h00, 10, 0, r);
      do_wr(3, 8'h5A, 2'b10);
      check_bank("R5 next transfer starts fresh");

      // random mix
      for (int t = 0; t < 300; t++) begin
         int idx, nb;
         bit rd;
         logic [7:0] d, e;
         logic [1:0] lo;
         idx = ($urandom % 8 == 0) ? 32 + int'($urandom % 32) : int'($urandom % 32);
         if ($urandom % 4 == 0) idx = ($urandom % 2) ? 5 : 16 + int'($urandom % 2);
         rd = $urandom % 2;
         d  = 8'($urandom);
         lo = 2'($urandom);
         stat_in = {$urandom, 8'($urandom)};
         if ($urandom % 8 == 0) begin
            nb = 1 + int'($urandom % 15);
            xfer(rd, {idx[5:0], lo}, d, nb, 0, r);
            check_bank("R5 random abort");
         end else if (rd) begin
            e = exp_read(idx);
            xfer(1, {idx[5:0], lo}, d, 16, 0, r);
            chk(r === e, "R1 R6 R7 random read", {24'h0, r}, {24'h0, e});
            check_bank("R4 random read no change");
         end else begin
            do_wr(idx, d, lo);
            check_bank("R1 R6 R9 random write");
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule